// File: doc/BRIEF.md
# Incremental Encoder Quadrature Decoder

This block turns the two phase lines and the index line of an incremental encoder into a signed-free position count, a direction bit and three event flags. Each raw line passes through a two-stage synchronizer and a glitch filter of programmable length. Before the filter, the lines can be inverted one by one, the two phases can be exchanged, and the index can be taken from the B phase line instead of its own pin.

In the default mode every edge of either phase is one step, so one full encoder cycle gives four counts. An optional mode counts only the edges of phase A, giving two counts per cycle. Each accepted step produces a one-cycle up or down pulse and moves the position counter. A change on both phases in the same filtered sample is reported as a quadrature error and is not counted. A reversal of direction and an index edge are also flagged. Each flag can be routed to a single interrupt line through its own mask bit.

Top module: `qdec_core`

## Requirements
- R1: After reset, `pos` is 0, `status` is 0, `irq_mask` is 0, and `irq`, `cnt_up` and `cnt_dn` are low.
- R2: In the default mode, each filtered transition of exactly one phase is one step. The step is up when the new A level differs from the previous B level, so the sequence (A,B) 00→10→11→01→00 counts up. Each step gives a one-cycle `cnt_up` or `cnt_dn` pulse, never both, and moves `pos` by one. `status[8]` holds the direction of the last step (1 = up).
- R3: A synchronized input level reaches the decoder only after it has been sampled for `cfg_filt`+1 consecutive clocks. A pulse shorter than that is dropped.
- R4: `cfg_inv_a` and `cfg_inv_b` invert their phase before decoding. With `cfg_inv_a` set, a raw up sequence counts down. `cfg_inv_idx` inverts the index input.
- R5: `cfg_swap` exchanges the two phases, so a raw up sequence counts down.
- R6: A rising edge of the conditioned index clears `pos` to 0 and sets flag bit 0 (`status[0]`). This clear wins over a step in the same cycle.
- R7: With `cfg_idx_on_b` set, the index is taken from the raw B line and the index pin is ignored.
- R8: With `cfg_a_only` set, only phase A transitions are steps (two per encoder cycle). B transitions give no step.
- R9: A transition of both phases in the same filtered sample sets flag bit 2 (`status[2]`). It gives no step and leaves `pos` unchanged.
- R10: A step whose direction differs from `status[8]` sets flag bit 1 (`status[1]`).
- R11: Flags are sticky until cleared by the matching `flag_clr` bit. An `irq_en_set` bit sets a mask bit and an `irq_en_dis` bit clears it. `irq` is high exactly when some flag and its mask bit are both set, with one cycle of latency.
- R12: With `cfg_en` low, no steps, pulses or flags are produced and `pos` holds. The decoder still tracks the input levels, so enabling it again produces no spurious step.
- R13: With `cfg_pos_en` low, `pos` holds, but `cnt_up`/`cnt_dn` pulses and the direction still follow the steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Raw phase A line |
| in_b | input | 1 | Raw phase B line |
| in_idx | input | 1 | Raw index line |
| cfg_en | input | 1 | Decoder enable |
| cfg_pos_en | input | 1 | Position counter enable |
| cfg_inv_a | input | 1 | Invert phase A |
| cfg_inv_b | input | 1 | Invert phase B |
| cfg_inv_idx | input | 1 | Invert index |
| cfg_swap | input | 1 | Exchange phases A and B |
| cfg_idx_on_b | input | 1 | Take index from the raw B line |
| cfg_a_only | input | 1 | Count phase A edges only |
| cfg_filt | input | FILT_W | Filter length minus one |
| flag_clr | input | 3 | Per-flag clear pulse |
| irq_en_set | input | 3 | Per-flag mask set pulse |
| irq_en_dis | input | 3 | Per-flag mask clear pulse |
| cnt_up | output | 1 | One-cycle up-step pulse |
| cnt_dn | output | 1 | One-cycle down-step pulse |
| pos | output | POS_W | Position count |
| status | output | 9 | Flags at bits 2:0 (index, direction change, error), direction at bit 8 |
| irq_mask | output | 3 | Current mask |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that configuration changes only while `cfg_en` is low. Changing inversion, swap or index routing while enabled flips a conditioned level, and that flip would be decoded as a real edge. The bench follows this rule: each reconfiguration drops `cfg_en`, waits until the filters settle, then raises it again. All raw edges are driven on the falling clock edge and held far longer than the filter window. The only exception is the glitch scenario, where pulse lengths are counted in exact clocks.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int NFLAG    = 3;
  localparam int FLG_IDX  = 0;
  localparam int FLG_DCHG = 1;
  localparam int FLG_QERR = 2;
  localparam int STAT_DIR = 8;
  localparam int STAT_W   = STAT_DIR + 1;
  localparam int NIN      = 3;   // conditioned lines: A, B, index
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int FILT_W = 6,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [FILT_W-1:0] limit,
  output logic              q
);
  logic [SYNC_N-1:0] sh;
  logic [FILT_W-1:0] cnt;
  logic              s;

  assign s = sh[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      sh <= {sh[SYNC_N-2:0], din};
      if (s == q) begin
        cnt <= '0;
      end else if (cnt == limit) begin
        q   <= s;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: a level that agrees with the output cannot move it
  p_filter_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (s == q) |=> $stable(q));
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic a_only,
  input  logic a,
  input  logic b,
  input  logic idx,
  output logic up_p,
  output logic dn_p,
  output logic dir,
  output logic idx_ev,
  output logic dchg_ev,
  output logic err_ev
);
  logic pa, pb, pidx;
  logic da, db, move, up, err, irise;

  always_comb begin
    da    = a ^ pa;
    db    = b ^ pb;
    err   = en & da & db;
    move  = en & ~(da & db) & (da | (~a_only & db));
    up    = a ^ pb;
    irise = en & idx & ~pidx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa <= 1'b0; pb <= 1'b0; pidx <= 1'b0;
      up_p <= 1'b0; dn_p <= 1'b0; dir <= 1'b0;
      idx_ev <= 1'b0; dchg_ev <= 1'b0; err_ev <= 1'b0;
    end else begin
      pa      <= a;
      pb      <= b;
      pidx    <= idx;
      up_p    <= move & up;
      dn_p    <= move & ~up;
      idx_ev  <= irise;
      err_ev  <= err;
      dchg_ev <= move & (up != dir);
      if (move) dir <= up;
    end
  end

  // R2: never both step pulses at once
  p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({up_p, dn_p}));
  // R9: simultaneous phase change gives no step
  p_err_no_step_r9: assert property (@(posedge clk) disable iff (rst)
    (en && (a != pa) && (b != pb)) |=> (!up_p && !dn_p));
  // R12: disabled decoder stays silent
  p_off_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!up_p && !dn_p && !idx_ev && !err_ev && !dchg_ev));
endmodule

// File: rtl/qdec_pos.sv
module qdec_pos #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pos_en,
  input  logic             up,
  input  logic             dn,
  input  logic             clr,
  output logic [POS_W-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst || clr)          pos <= '0;
    else if (pos_en && up)   pos <= pos + 1'b1;
    else if (pos_en && dn)   pos <= pos - 1'b1;
  end

  // R6: index clear wins
  p_idx_clears_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pos == '0));
  // R13: counter frozen while position counting is off
  p_pos_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!pos_en && !clr) |=> $stable(pos));
endmodule

// File: rtl/qdec_core.sv
module qdec_core
  import qdec_pkg::*;
#(
  parameter int POS_W  = 16,
  parameter int FILT_W = 6,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_idx,
  input  logic              cfg_en,
  input  logic              cfg_pos_en,
  input  logic              cfg_inv_a,
  input  logic              cfg_inv_b,
  input  logic              cfg_inv_idx,
  input  logic              cfg_swap,
  input  logic              cfg_idx_on_b,
  input  logic              cfg_a_only,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic [NFLAG-1:0]  flag_clr,
  input  logic [NFLAG-1:0]  irq_en_set,
  input  logic [NFLAG-1:0]  irq_en_dis,
  output logic              cnt_up,
  output logic              cnt_dn,
  output logic [POS_W-1:0]  pos,
  output logic [STAT_W-1:0] status,
  output logic [NFLAG-1:0]  irq_mask,
  output logic              irq
);
  logic             ca, cb;
  logic [NIN-1:0]   cond, flt;
  logic             dir, idx_ev, dchg_ev, err_ev;
  logic [NFLAG-1:0] flags, ev;

  // input conditioning: invert, then swap, then pick the index source
  always_comb begin
    ca      = in_a ^ cfg_inv_a;
    cb      = in_b ^ cfg_inv_b;
    cond[0] = cfg_swap ? cb : ca;
    cond[1] = cfg_swap ? ca : cb;
    cond[2] = (cfg_idx_on_b ? in_b : in_idx) ^ cfg_inv_idx;
  end

  for (genvar g = 0; g < NIN; g++) begin : g_flt
    qdec_filter #(.FILT_W(FILT_W), .SYNC_N(SYNC_N)) u_flt (
      .clk(clk), .rst(rst), .din(cond[g]), .limit(cfg_filt), .q(flt[g]));
  end

  qdec_decode u_dec (
    .clk(clk), .rst(rst), .en(cfg_en), .a_only(cfg_a_only),
    .a(flt[0]), .b(flt[1]), .idx(flt[2]),
    .up_p(cnt_up), .dn_p(cnt_dn), .dir(dir),
    .idx_ev(idx_ev), .dchg_ev(dchg_ev), .err_ev(err_ev));

  qdec_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .pos_en(cfg_pos_en),
    .up(cnt_up), .dn(cnt_dn), .clr(idx_ev), .pos(pos));

  always_comb begin
    ev           = '0;
    ev[FLG_IDX]  = idx_ev;
    ev[FLG_DCHG] = dchg_ev;
    ev[FLG_QERR] = err_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      irq_mask <= '0;
      irq      <= 1'b0;
    end else begin
      flags    <= (flags & ~flag_clr) | ev;
      irq_mask <= (irq_mask | irq_en_set) & ~irq_en_dis;
      irq      <= |(flags & irq_mask);
    end
  end

  always_comb begin
    status                = '0;
    status[NFLAG-1:0]     = flags;
    status[STAT_DIR]      = dir;
  end

  // R11: no request without a mask bit set one cycle earlier
  p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> |$past(irq_mask));
  // R9: an error event is latched into its flag
  p_err_flag_r9: assert property (@(posedge clk) disable iff (rst)
    err_ev |=> status[FLG_QERR]);
endmodule

// File: tb/tb_qdec_core.sv
module tb_qdec_core;
  localparam int POS_W = 16;
  localparam int FILT_W = 6;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_a = 0, in_b = 0, in_idx = 0;
  logic cfg_en = 1, cfg_pos_en = 1, cfg_inv_a = 0, cfg_inv_b = 0;
  logic cfg_inv_idx = 0, cfg_swap = 0, cfg_idx_on_b = 0, cfg_a_only = 0;
  logic [FILT_W-1:0] cfg_filt = 6'd3;
  logic [2:0] flag_clr = 0, irq_en_set = 0, irq_en_dis = 0;
  logic cnt_up, cnt_dn, irq;
  logic [POS_W-1:0] pos;
  logic [8:0] status;
  logic [2:0] irq_mask;

  int total = 0, bad = 0, ups = 0, dns = 0;
  logic [POS_W-1:0] exp_pos = '0;

  always #2.5 clk = ~clk;

  qdec_core #(.POS_W(POS_W), .FILT_W(FILT_W)) dut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
    .cfg_en(cfg_en), .cfg_pos_en(cfg_pos_en), .cfg_inv_a(cfg_inv_a),
    .cfg_inv_b(cfg_inv_b), .cfg_inv_idx(cfg_inv_idx), .cfg_swap(cfg_swap),
    .cfg_idx_on_b(cfg_idx_on_b), .cfg_a_only(cfg_a_only), .cfg_filt(cfg_filt),
    .flag_clr(flag_clr), .irq_en_set(irq_en_set), .irq_en_dis(irq_en_dis),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .pos(pos), .status(status),
    .irq_mask(irq_mask), .irq(irq));

  always @(posedge clk) begin
    if (!rst) begin
      ups <= ups + int'(cnt_up);
      dns <= dns + int'(cnt_dn);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raw up step: (A,B) 00->10->11->01->00
  task automatic raw_up(input int n);
    for (int i = 0; i < n; i++) begin
      logic na, nb;
      na = ~in_b; nb = in_a;
      in_a = na; in_b = nb;
      wait_clk(SETTLE);
    end
  endtask

  task automatic raw_dn(input int n);
    for (int i = 0; i < n; i++) begin
      logic na, nb;
      na = in_b; nb = ~in_a;
      in_a = na; in_b = nb;
      wait_clk(SETTLE);
    end
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111; wait_clk(1); flag_clr = 3'b000; wait_clk(2);
  endtask

  task automatic quiet_cfg();
    cfg_en = 0; wait_clk(SETTLE);
  endtask

  task automatic resume();
    wait_clk(SETTLE); cfg_en = 1; wait_clk(2);
  endtask

  task automatic t_reset();
    chk("R1 pos", int'(pos), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 irq/mask", int'({irq, irq_mask, cnt_up, cnt_dn}), 0);
  endtask

  task automatic t_count();
    int u0 = ups;
    raw_up(8); exp_pos += 8;
    chk("R2 pos after 8 up", int'(pos), int'(exp_pos));
    chk("R2 up pulses", ups - u0, 8);
    chk("R2 dir up", int'(status[8]), 1);
    clear_flags();
    chk("R11 flags cleared", int'(status[2:0]), 0);
    raw_dn(3); exp_pos -= 3;
    chk("R2 pos after 3 down", int'(pos), int'(exp_pos));
    chk("R2 dir down", int'(status[8]), 0);
    chk("R10 dir change flag", int'(status[1]), 1);
  endtask

  task automatic t_filter();
    int u0 = ups, d0 = dns;
    clear_flags();
    in_a = ~in_a; wait_clk(3); in_a = ~in_a; wait_clk(SETTLE);
    chk("R3 short glitch pos", int'(pos), int'(exp_pos));
    chk("R3 short glitch pulses", (ups - u0) + (dns - d0), 0);
    in_a = ~in_a; wait_clk(4); in_a = ~in_a; wait_clk(SETTLE);
    chk("R3 long pulse up", ups - u0, 1);
    chk("R3 long pulse down", dns - d0, 1);
    chk("R3 long pulse pos", int'(pos), int'(exp_pos));
  endtask

  task automatic t_err();
    int u0 = ups, d0 = dns;
    clear_flags();
    in_a = ~in_a; in_b = ~in_b; wait_clk(SETTLE);
    chk("R9 error flag", int'(status[2]), 1);
    chk("R9 pos held", int'(pos), int'(exp_pos));
    chk("R9 no pulses", (ups - u0) + (dns - d0), 0);
  endtask

  task automatic t_inv();
    quiet_cfg(); cfg_inv_a = 1; resume();
    raw_up(2); exp_pos -= 2;
    chk("R4 inverted A reverses", int'(pos), int'(exp_pos));
    quiet_cfg(); cfg_inv_a = 0; resume();
  endtask

  task automatic t_swap();
    quiet_cfg(); cfg_swap = 1; resume();
    raw_up(3); exp_pos -= 3;
    chk("R5 swap reverses", int'(pos), int'(exp_pos));
    quiet_cfg(); cfg_swap = 0; resume();
  endtask

  task automatic t_aonly();
    quiet_cfg(); cfg_a_only = 1; resume();
    raw_up(4); exp_pos += 2;
    chk("R8 A-only half rate", int'(pos), int'(exp_pos));
    quiet_cfg(); cfg_a_only = 0; resume();
  endtask

  task automatic t_idx();
    clear_flags();
    in_idx = 1; wait_clk(SETTLE); in_idx = 0; wait_clk(SETTLE);
    exp_pos = '0;
    chk("R6 index clears pos", int'(pos), 0);
    chk("R6 index flag", int'(status[0]), 1);
    quiet_cfg(); cfg_inv_idx = 1; resume();
    raw_up(2); exp_pos += 2;
    clear_flags();
    in_idx = 1; wait_clk(SETTLE);
    chk("R4 inverted index ignores rise", int'(pos), int'(exp_pos));
    in_idx = 0; wait_clk(SETTLE); exp_pos = '0;
    chk("R4 inverted index clears on fall", int'(pos), 0);
    quiet_cfg(); cfg_inv_idx = 0; resume();
  endtask

  task automatic t_idx_b();
    while (in_b) raw_up(1);
    exp_pos = pos;
    quiet_cfg(); cfg_a_only = 1; cfg_idx_on_b = 1; resume();
    in_a = ~in_a; wait_clk(SETTLE);
    exp_pos = in_a ? exp_pos + 1'b1 : exp_pos - 1'b1;
    chk("R8 single A step", int'(pos), int'(exp_pos));
    clear_flags();
    in_idx = 1; wait_clk(SETTLE);
    chk("R7 index pin ignored", int'(status[0]), 0);
    in_idx = 0;
    in_b = 1; wait_clk(SETTLE); exp_pos = '0;
    chk("R7 B line clears pos", int'(pos), 0);
    chk("R7 B line sets index flag", int'(status[0]), 1);
    quiet_cfg(); cfg_a_only = 0; cfg_idx_on_b = 0; resume();
  endtask

  task automatic t_irq();
    chk("R11 no irq unmasked", int'(irq), 0);
    irq_en_set = 3'b001; wait_clk(1); irq_en_set = 0; wait_clk(3);
    chk("R11 mask set", int'(irq_mask), 1);
    chk("R11 irq raised", int'(irq), 1);
    flag_clr = 3'b001; wait_clk(1); flag_clr = 0; wait_clk(3);
    chk("R11 irq drops with flag", int'(irq), 0);
    irq_en_dis = 3'b001; wait_clk(1); irq_en_dis = 0; wait_clk(2);
    chk("R11 mask cleared", int'(irq_mask), 0);
  endtask

  task automatic t_enables();
    int u0, d0;
    clear_flags();
    u0 = ups; d0 = dns;
    cfg_en = 0; raw_up(2); wait_clk(2);
    chk("R12 pos held when off", int'(pos), int'(exp_pos));
    chk("R12 no pulses when off", (ups - u0) + (dns - d0), 0);
    chk("R12 no flags when off", int'(status[2:0]), 0);
    cfg_en = 1; wait_clk(SETTLE);
    chk("R12 no step on re-enable", (ups - u0) + (dns - d0), 0);
    u0 = ups;
    cfg_pos_en = 0; raw_up(2);
    chk("R13 pos held", int'(pos), int'(exp_pos));
    chk("R13 pulses still issued", ups - u0, 2);
    cfg_pos_en = 1; wait_clk(2);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(4); rst = 0; wait_clk(2);
    t_reset();
    t_count();
    t_filter();
    t_err();
    t_inv();
    t_swap();
    t_aonly();
    t_idx();
    t_idx_b();
    t_irq();
    t_enables();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule